// File: doc/BRIEF.md
# Receive Byte Ring Buffer with Occupancy Watermark

This block sits between a serial receive path and a packet decoder. Bytes arrive on a strobe from one writer. A single reader takes them out in arrival order. The storage holds four 64-byte packets by default, which is 256 bytes. The reader always sees the oldest stored byte on its data output, and a pop request consumes that byte.

Besides the usual empty and full indications, the block gives software two figures for sizing the buffer. The first is a peak-occupancy watermark that only rises until it is cleared. The second is a saturating count of bytes that were lost because they arrived while the storage was full. A clear strobe restarts a measurement window. At that point the watermark drops to the present fill level and the loss count returns to zero.

Top module: `rxbyte_ring`

## Requirements
- R1: Bytes leave in the order they were accepted. When the buffer is not empty, `rd_data` shows the oldest stored byte.
- R2: `level` equals bytes accepted minus bytes popped, from 0 to 2^AW. `empty` is high exactly when `level` is 0, and `full` is high exactly when `level` is 2^AW.
- R3: A write strobe while `full` is high and `rd_req` is low is an overrun. The byte is discarded, `drop` is high in that cycle, and the level and the stored contents stay unchanged.
- R4: A write and a read in the same cycle while full are both accepted. `drop` stays low and the level stays at 2^AW.
- R5: A read request while empty is ignored. The level stays 0 and no byte is consumed.
- R6: `peak` holds the largest `level` reached since reset or the last clear. It never falls unless a clear arrives.
- R7: A cycle with `clr_stats` high loads `peak` with the level that results from that cycle and sets `ovf_count` to 0. An overrun in the same cycle is not counted.
- R8: `ovf_count` rises by one per overrun and saturates at 2^CW-1 without wrapping.
- R9: After reset the buffer is empty and `level`, `peak` and `ovf_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Incoming byte strobe |
| wr_data | input | 8 | Incoming byte |
| rd_req | input | 1 | Pop the oldest byte |
| rd_data | output | 8 | Oldest stored byte |
| empty | output | 1 | No bytes stored |
| full | output | 1 | Storage holds 2^AW bytes |
| drop | output | 1 | Overrun in this cycle |
| clr_stats | input | 1 | Restart watermark and loss count |
| level | output | AW+1 | Current occupancy |
| peak | output | AW+1 | Peak occupancy since last clear |
| ovf_count | output | CW | Saturating overrun count |

## Verification
The bench fills the buffer to its exact capacity, where a pointer comparison without the wrap bit would read the buffer as empty and lose all 256 bytes. It then forces overruns and checks that the stored bytes survive unchanged, which catches a design that overwrites the oldest byte. It also sends more than 255 overruns, so a counter that wraps to zero is caught. A push and a pop in the same cycle at full must not be flagged as an overrun. A pop on empty must not make the level go below zero. A clear while bytes are stored must set the watermark to that fill level and not to zero.

// File: rtl/rxbyte_ring.sv
module rxbyte_ring #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  input  logic          rd_req,
  output logic [7:0]    rd_data,
  output logic          empty,
  output logic          full,
  output logic          drop,
  input  logic          clr_stats,
  output logic [AW:0]   level,
  output logic [AW:0]   peak,
  output logic [CW-1:0] ovf_count
);
  localparam int DEPTH = 1 << AW;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [7:0]  mem [DEPTH];
  logic [AW:0] wptr, rptr, level_nx;
  logic        do_push, do_pop;

  assign empty   = (wptr == rptr);
  assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign level   = wptr - rptr;
  assign do_pop  = rd_req && !empty;
  assign do_push = wr_valid && (!full || rd_req);
  assign drop    = wr_valid && full && !rd_req;
  assign rd_data = mem[rptr[AW-1:0]];
  assign level_nx = level + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak      <= '0;
      ovf_count <= '0;
    end else if (clr_stats) begin
      peak      <= level_nx;
      ovf_count <= '0;
    end else begin
      if (level_nx > peak) peak <= level_nx;
      if (drop && ovf_count != CMAX) ovf_count <= ovf_count + 1'b1;
    end
  end
endmodule

// File: rtl/rxbyte_ring_chk.sv
module rxbyte_ring_chk #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          rd_req,
  input logic          clr_stats,
  input logic          empty,
  input logic          full,
  input logic          drop,
  input logic [AW:0]   level,
  input logic [AW:0]   peak,
  input logic [CW-1:0] ovf_count
);
  localparam int DEPTH = 1 << AW;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n) level <= (AW+1)'(DEPTH)); // R2
  AST_FULL_FLAG:   assert property (@(posedge clk) disable iff (!rst_n) full == (level == (AW+1)'(DEPTH))); // R2
  AST_DROP_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) drop |=> full); // R3
  AST_FULL_SWAP:   assert property (@(posedge clk) disable iff (!rst_n) (full && wr_valid && rd_req) |=> full); // R4
  AST_FULL_NODROP: assert property (@(posedge clk) disable iff (!rst_n) (full && wr_valid && rd_req) |-> !drop); // R4
  AST_EMPTY_POP:   assert property (@(posedge clk) disable iff (!rst_n) (empty && rd_req && !wr_valid) |=> empty); // R5
  AST_PEAK_ABOVE:  assert property (@(posedge clk) disable iff (!rst_n) peak >= level); // R6
  AST_PEAK_MONO:   assert property (@(posedge clk) disable iff (!rst_n) !clr_stats |=> peak >= $past(peak)); // R6
  AST_CLR_ZERO:    assert property (@(posedge clk) disable iff (!rst_n) clr_stats |=> ovf_count == '0); // R7
  AST_CNT_SAT:     assert property (@(posedge clk) disable iff (!rst_n) (ovf_count == CMAX && !clr_stats) |=> ovf_count == CMAX); // R8
endmodule

bind rxbyte_ring rxbyte_ring_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_req(rd_req),
  .clr_stats(clr_stats), .empty(empty), .full(full), .drop(drop),
  .level(level), .peak(peak), .ovf_count(ovf_count)
);

// File: tb/rxbyte_ring_test.sv
module rxbyte_ring_test;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, rd_req = 0, clr_stats = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic empty, full, drop;
  logic [AW:0] level, peak;
  logic [CW-1:0] ovf_count;

  int errors = 0, checks = 0;
  byte unsigned q[$];
  int mpeak = 0, mcnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  rxbyte_ring #(.AW(AW), .CW(CW)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(level == q.size(), {req, " level"}, level, q.size());
    chk(empty == (q.size() == 0), "R2 empty", empty, q.size() == 0);
    chk(full == (q.size() == DEPTH), "R2 full", full, q.size() == DEPTH);
    chk(peak == mpeak, {req, " peak"}, peak, mpeak);
    chk(ovf_count == mcnt, {req, " ovf_count"}, ovf_count, mcnt);
  endtask

  task automatic cyc(input bit w, input byte unsigned d, input bit r, input bit c, input string req);
    bit mfull, pop, push, ovr;
    @(negedge clk);
    wr_valid = w; wr_data = d; rd_req = r; clr_stats = c;
    mfull = (q.size() == DEPTH);
    pop  = r && q.size() > 0;
    push = w && (!mfull || r);
    ovr  = w && mfull && !r;
    #1;
    if (pop) chk(rd_data == q[0], "R1 order", rd_data, q[0]);
    chk(drop == ovr, mfull && w && r ? "R4 drop" : "R3 drop", drop, ovr);
    @(posedge clk);
    if (pop) void'(q.pop_front());
    if (push) q.push_back(d);
    if (c) begin
      mpeak = q.size(); mcnt = 0;
    end else begin
      if (q.size() > mpeak) mpeak = q.size();
      if (ovr && mcnt < CMAX) mcnt++;
    end
    #1;
    chk_state(req);
  endtask

  initial begin
    #10000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #23; chk_state("R9");
    rst_n = 1;
    cyc(0, 0, 1, 0, "R5");
    cyc(0, 0, 1, 0, "R5");
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i * 7 + 3), 0, 0, "R2");
    for (int i = 0; i < 3; i++) cyc(1, 8'hEE, 0, 0, "R3");
    cyc(1, 8'h5A, 1, 0, "R4");
    cyc(1, 8'h5B, 1, 0, "R4");
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 0, "R1");
    cyc(0, 0, 0, 1, "R7");
    for (int i = 0; i < 10; i++) cyc(1, 8'(i), 0, 0, "R6");
    for (int i = 0; i < CMAX + 45; i++) cyc(1, 8'hFF, 0, 0, "R8");
    cyc(1, 8'hFF, 0, 1, "R7");
    for (int i = 0; i < DEPTH + 4; i++) cyc(0, 0, 1, 0, "R1");
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] | lfsr[1], lfsr[15:8], lfsr[2] & lfsr[3], lfsr[11:4] == 8'h3C, "R6");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule